// File: doc/BRIEF.md
# Timed Write-Protect Bit Controller

This block keeps the single protect bit that guards a timekeeping register file against stray writes. It watches a chip-select line that is high only while the main supply is valid, and it receives one-bit write strobes that try to set or clear the bit. A set request takes effect on the next clock edge unless chip-select is low or a short lockout that follows every clear is still running. A clear request is harder to get through. It is only taken while chip-select has been high long enough since it last rose. After that, chip-select must stay high for a longer hold window before the bit actually drops.

All three windows are measured in pulses of a prescaled timebase tick. Each window is converted from nanoseconds to ticks with one tick of margin, so the window is never shorter than specified, whatever the tick phase. Besides the protect bit, the block drives a write-inhibit for the registers that serve as plain storage while the calendar is off. It powers up protected.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset the protect bit is 1, no clear is pending and no set lockout is running.
- R2: A write with value 1 while chip-select is high and no lockout runs makes the protect bit 1 at the next clock edge. It also cancels any pending clear.
- R3: A write with value 1 while chip-select is low has no effect on the protect bit.
- R4: When the protect bit falls from 1 to 0, a set lockout starts. A write with value 1 is ignored until LOCK_T ticks have been counted after the fall, including the cycle in which the last of them is seen.
- R5: A write with value 0 is taken only if the protect bit is 1, no clear is pending, chip-select is high, and at least QUAL_T ticks were counted while chip-select stayed high since its last rise. The tick count restarts at 0 whenever chip-select is low. An early write is discarded and not queued.
- R6: A taken clear becomes pending. The protect bit falls at the edge that ends the first cycle in which HOLD_T ticks have been counted since the write, provided chip-select is high in that cycle.
- R7: If chip-select is low in any cycle while a clear is pending, the clear is dropped and the protect bit stays 1.
- R8: The write-inhibit output is 1 exactly when the protect bit is 1 and the register file is in plain-storage mode (mode input 1).
- R9: Each window in ticks is ceil(window_ns / TICK_NS) + 1. The defaults are 62 us (lockout), 2 ms (qualify) and 11 ms (hold).
- R10: A write with value 1 in the cycle where a pending clear would complete wins, and the bit stays 1. A write with value 0 while a clear is pending neither restarts nor delays it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle timebase pulse |
| cs_i | input | 1 | Chip-select, high while the main supply is valid |
| wr_i | input | 1 | Write strobe for the protect bit |
| wr_val_i | input | 1 | Value written with the strobe |
| ram_mode_i | input | 1 | 1 when the date and year registers serve as plain storage |
| prot_o | output | 1 | Current protect bit |
| ram_wr_inhibit_o | output | 1 | Blocks writes into the plain-storage registers |

## Verification
Two events can meet in one cycle: completion of a pending clear, and a new write of 1. A third event, chip-select falling, can also land on the completion cycle. The bench counts the tick pulses seen after a taken clear and then places a write of 1 exactly in the completion cycle. It judges the result by whether the protect bit stays 1 and no lockout is left behind: the next clear and set must behave normally. A cycle-level reference built from the requirements is compared at every falling edge. It catches any off-by-one in where the windows end.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    // window length in ticks: rounded up, plus one tick for unknown tick phase
    function automatic int unsigned win_ticks(input int unsigned span_ns,
                                              input int unsigned tick_ns);
        return (span_ns + tick_ns - 1) / tick_ns + 1;
    endfunction

    typedef struct packed {
        logic prot;   // protect bit
        logic pend;   // clear waiting for hold window
        logic lock;   // set lockout after a clear
    } wprot_st_t;

endpackage

// File: rtl/wprot_tick_cnt.sv
module wprot_tick_cnt #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (run_i && tick_i && (cnt_q != LIM)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == LIM);

    AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == LIM) && !clr_i |=> cnt_q == LIM); // R9

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl #(
    parameter int unsigned TICK_NS = 30518,
    parameter int unsigned LOCK_NS = 62000,
    parameter int unsigned QUAL_NS = 2000000,
    parameter int unsigned HOLD_NS = 11000000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic cs_i,
    input  logic wr_i,
    input  logic wr_val_i,
    input  logic ram_mode_i,
    output logic prot_o,
    output logic ram_wr_inhibit_o
);
    import wprot_pkg::*;

    localparam int unsigned LOCK_T = win_ticks(LOCK_NS, TICK_NS);
    localparam int unsigned QUAL_T = win_ticks(QUAL_NS, TICK_NS);
    localparam int unsigned HOLD_T = win_ticks(HOLD_NS, TICK_NS);

    wprot_st_t st_d, st_q;
    logic cs_aged, hold_done, lock_done;
    logic set_ok, clr_ok, clr_done;

    // chip-select age: cleared while low, counts ticks while high
    wprot_tick_cnt #(.LIMIT(QUAL_T)) u_cs_age (
        .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(!cs_i), .run_i(cs_i),
        .tick_i(tick_i), .done_o(cs_aged));

    // hold window of a pending clear
    wprot_tick_cnt #(.LIMIT(HOLD_T)) u_hold (
        .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(!st_q.pend), .run_i(st_q.pend),
        .tick_i(tick_i), .done_o(hold_done));

    // set lockout after the bit falls
    wprot_tick_cnt #(.LIMIT(LOCK_T)) u_lock (
        .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(!st_q.lock), .run_i(st_q.lock),
        .tick_i(tick_i), .done_o(lock_done));

    always_comb begin
        set_ok   = wr_i && wr_val_i && cs_i && !st_q.lock;
        clr_ok   = wr_i && !wr_val_i && cs_i && cs_aged && st_q.prot && !st_q.pend;
        clr_done = st_q.pend && hold_done && cs_i;

        st_d = st_q;
        if (st_q.lock && lock_done) st_d.lock = 1'b0;
        if (st_q.pend && !cs_i)     st_d.pend = 1'b0;
        if (clr_ok)                 st_d.pend = 1'b1;
        if (clr_done) begin
            st_d.prot = 1'b0;
            st_d.pend = 1'b0;
            st_d.lock = 1'b1;
        end
        if (set_ok) begin
            st_d.prot = 1'b1;
            st_d.pend = 1'b0;
            st_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{prot: 1'b1, pend: 1'b0, lock: 1'b0};
        else         st_q <= st_d;
    end

    assign prot_o           = st_q.prot;
    assign ram_wr_inhibit_o = st_q.prot && ram_mode_i;

    AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i && wr_val_i && cs_i && !st_q.lock |=> st_q.prot); // R2
    AST_SET_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_i && !st_q.prot |=> !st_q.prot); // R3
    AST_LOCK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.lock && !st_q.prot |=> !st_q.prot); // R4
    AST_FALL_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.prot) |-> $past(st_q.pend) && $past(cs_i)); // R6
    AST_CS_DROPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pend && !cs_i |=> !st_q.pend && st_q.prot); // R7
    AST_PEND_ONLY_PROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pend |-> st_q.prot && !st_q.lock); // R5

endmodule

// File: tb/wprot_ctrl_bench.sv
module wprot_ctrl_bench;
    localparam int unsigned TICK_NS = 500000;
    // R9: expected windows computed here: ceil(ns/tick)+1
    localparam int LOCK_T = (62000    + TICK_NS - 1) / TICK_NS + 1;  // 2
    localparam int QUAL_T = (2000000  + TICK_NS - 1) / TICK_NS + 1;  // 5
    localparam int HOLD_T = (11000000 + TICK_NS - 1) / TICK_NS + 1;  // 23

    logic clk = 0, rst_n = 0, tick = 0, cs = 0, wr = 0, wr_val = 0, ram_mode = 0;
    logic prot, inhibit;
    int n_chk = 0, n_bad = 0, cyc_cnt = 0, tdiv = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wprot_ctrl #(.TICK_NS(TICK_NS)) u_wprot_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cs_i(cs), .wr_i(wr),
        .wr_val_i(wr_val), .ram_mode_i(ram_mode), .prot_o(prot),
        .ram_wr_inhibit_o(inhibit));

    // timebase: one pulse every 3 cycles
    always @(posedge clk) begin
        #2;
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        tick = (tdiv == 0);
    end

    // reference built from the requirements
    logic m_prot = 1, m_pend = 0, m_lock = 0;
    int m_cs = 0, m_hold = 0, m_lk = 0;
    always @(posedge clk) begin
        bit aged, hdone, ldone, s_ok, c_ok, c_done;
        if (!rst_n) begin
            m_prot = 1; m_pend = 0; m_lock = 0; m_cs = 0; m_hold = 0; m_lk = 0;
        end else begin
            aged = (m_cs >= QUAL_T); hdone = (m_hold >= HOLD_T); ldone = (m_lk >= LOCK_T);
            s_ok = wr && wr_val && cs && !m_lock;
            c_ok = wr && !wr_val && cs && aged && m_prot && !m_pend;
            c_done = m_pend && hdone && cs;
            m_cs   = !cs ? 0 : (tick && m_cs < QUAL_T) ? m_cs + 1 : m_cs;
            m_hold = !m_pend ? 0 : (tick && m_hold < HOLD_T) ? m_hold + 1 : m_hold;
            m_lk   = !m_lock ? 0 : (tick && m_lk < LOCK_T) ? m_lk + 1 : m_lk;
            if (m_lock && ldone) m_lock = 0;
            if (m_pend && !cs)   m_pend = 0;
            if (c_ok)            m_pend = 1;
            if (c_done) begin m_prot = 0; m_pend = 0; m_lock = 1; end
            if (s_ok)   begin m_prot = 1; m_pend = 0; m_lock = 0; end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc_cnt);
        end
    endtask

    // per-cycle comparison against the reference (R6 timing, R8 inhibit)
    always @(negedge clk) begin
        cyc_cnt++;
        if (rst_n && !done) begin
            check("R6 model prot", prot, m_prot);
            check("R8 model inhibit", inhibit, m_prot && ram_mode);
        end
        if (cyc_cnt > 150000 && !done) begin
            done = 1; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!tick);
        end
    endtask

    task automatic write(input logic v);
        @(posedge clk); #2; wr = 1; wr_val = v;
        @(posedge clk); #2; wr = 0;
    endtask

    task automatic set_cs(input logic v);
        @(posedge clk); #2; cs = v;
    endtask

    // bring the bit to 0 with a full qualified clear
    task automatic do_clear();
        set_cs(0); cycles(2); set_cs(1);
        wait_ticks(QUAL_T);
        write(0);
        wait_ticks(HOLD_T + 1);
        cycles(2);
    endtask

    initial begin
        ram_mode = 1;
        cycles(3);
        @(negedge clk);
        check("R1 reset prot", prot, 1'b1);
        check("R8 reset inhibit", inhibit, 1'b1);
        rst_n = 1;
        cycles(2);

        // R5/R9 sweep: write 0 after d ticks of chip-select high
        for (int d = 0; d <= QUAL_T + 1; d++) begin
            set_cs(0); cycles(2); set_cs(1);
            wait_ticks(d);
            write(0);
            wait_ticks(HOLD_T + 1);
            cycles(2);
            @(negedge clk);
            check($sformatf("R5 qualify d=%0d", d), prot, (d >= QUAL_T) ? 1'b0 : 1'b1);
            ram_mode = ~ram_mode;
            wait_ticks(LOCK_T + 1);
            write(1);
            @(negedge clk);
            check("R2 set after lockout", prot, 1'b1);
        end

        // R7: chip-select drops during the hold window
        set_cs(0); cycles(2); set_cs(1);
        wait_ticks(QUAL_T);
        write(0);
        wait_ticks(HOLD_T / 2);
        set_cs(0); cycles(4); set_cs(1);
        wait_ticks(HOLD_T + 3);
        @(negedge clk);
        check("R7 dropped clear", prot, 1'b1);

        // R3: set with chip-select low
        do_clear();
        wait_ticks(LOCK_T + 1);
        set_cs(0);
        write(1);
        @(negedge clk);
        check("R3 set ignored cs low", prot, 1'b0);
        set_cs(1);
        write(1);
        @(negedge clk);
        check("R2 set cs high", prot, 1'b1);

        // R4: set right after the fall is locked out
        do_clear();
        write(1);
        @(negedge clk);
        check("R4 set in lockout", prot, 1'b0);
        wait_ticks(LOCK_T + 1);
        write(1);
        @(negedge clk);
        check("R4 set after lockout", prot, 1'b1);

        // R2: set cancels a pending clear
        set_cs(0); cycles(2); set_cs(1);
        wait_ticks(QUAL_T);
        write(0);
        wait_ticks(3);
        write(1);
        wait_ticks(HOLD_T + 2);
        @(negedge clk);
        check("R2 set cancels pending", prot, 1'b1);

        // R10: write 1 in the completion cycle
        set_cs(0); cycles(2); set_cs(1);
        wait_ticks(QUAL_T);
        write(0);
        wait_ticks(HOLD_T);
        @(posedge clk); #2; wr = 1; wr_val = 1;
        @(posedge clk); #2; wr = 0;
        cycles(3);
        @(negedge clk);
        check("R10 set wins completion", prot, 1'b1);
        do_clear();
        @(negedge clk);
        check("R10 no stale lockout effect", prot, 1'b0);
        wait_ticks(LOCK_T + 1);
        write(1);

        // R10: second write 0 while pending does not restart
        set_cs(0); cycles(2); set_cs(1);
        wait_ticks(QUAL_T);
        write(0);
        wait_ticks(5);
        write(0);
        wait_ticks(HOLD_T - 5 + 1);
        cycles(2);
        @(negedge clk);
        check("R10 no restart", prot, 1'b0);
        wait_ticks(LOCK_T + 1);
        write(1);
        cycles(3);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule